// File: doc/BRIEF.md
# Strobed Output Handshake Channel

This block is one output channel of an 8-bit parallel port that uses a two-wire handshake with a peripheral. A CPU write strobe (active low, asynchronous to the system clock) loads a byte into the output latch. When the strobe is released, the channel pulls its active-low buffer-full line down to tell the peripheral that a new byte is waiting. The peripheral takes the byte and answers with an active-low acknowledge. The acknowledge releases the buffer-full line, and an interrupt request can then be raised toward the CPU if its enable flag is set.

Both the write strobe and the acknowledge are brought into the clock domain through a synchronizer of configurable depth, and all edges are detected in that domain. The enable flag is set and cleared by single-cycle inputs. A mode-write pulse returns the channel to its idle state. A three-bit status slice gives the buffer-full level, the enable flag and the interrupt in the bit order of the group that the channel serves. An optional bidirectional setting enables the port driver only while the acknowledge is low, and releases it otherwise.

Top module: `strobe_out_channel`

## Requirements
- R1: After reset, `obfN` is 1, `intr` is 0, `portOut` is all zeros and the enable flag in the status slice is 0.
- R2: Two to `SYNC_STAGES`+2 cycles after `cpuWrN` rises, the byte on `cpuData` is on `portOut` and `obfN` is 0. `cpuData` must stay stable from the falling edge of the strobe until that point.
- R3: While the synchronized `ackN` is low and no write edge is detected, the next clock edge drives `obfN` to 1.
- R4: `intr` is 1 one cycle after the enable flag is 1, the synchronized write strobe and acknowledge are both high and `obfN` is 1. In every other case it returns to 0 on the next edge.
- R5: The synchronized falling edge of `cpuWrN` drives `intr` to 0 on the next clock edge, and it stays 0 while the strobe is low.
- R6: `inteSet` sets the enable flag and `inteClr` clears it. When both are high, the clear wins. While the flag is 0, `intr` stays 0.
- R7: A `modeWrite` pulse clears the latch to zero, drives `obfN` to 1, and clears the enable flag and `intr`. It takes priority over a write edge in the same cycle.
- R8: If a write edge and a low acknowledge are seen in the same cycle, the write wins and `obfN` goes to 0.
- R9: With `BIDIR`=1, `portOe` equals the inverse of the synchronized acknowledge. With `BIDIR`=0, `portOe` is always 1.
- R10: With `GROUP_B`=0, `status` is {obfN, enable, intr} from bit 2 down to bit 0. With `GROUP_B`=1, it is {enable, obfN, intr}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| cpuWrN | input | 1 | CPU write strobe, active low, asynchronous |
| cpuData | input | DATA_W | CPU write data |
| ackN | input | 1 | Peripheral acknowledge, active low, asynchronous |
| modeWrite | input | 1 | Single-cycle pulse that returns the channel to idle |
| inteSet | input | 1 | Sets the interrupt enable flag |
| inteClr | input | 1 | Clears the interrupt enable flag |
| obfN | output | 1 | Buffer full, active low |
| portOut | output | DATA_W | Output latch value |
| portOe | output | 1 | Port driver enable |
| intr | output | 1 | Interrupt request |
| status | output | 3 | Status slice, bit order set by GROUP_B |

## Verification
The bench builds two instances that receive the same stimulus. The first uses `BIDIR`=1 with the group A status order. The second uses `BIDIR`=0 with the group B order. Together they cover both driver-enable behaviours and both status orderings in one run. Both use the default two-stage synchronizer and an 8-bit port. With these settings, the same-cycle race between a write edge and a one-cycle acknowledge can be set up directly from the port edges.

// File: rtl/soch_pkg.sv
package soch_pkg;
  localparam int STATUS_W = 3;

  typedef struct packed {
    logic clearAll;
    logic loadData;
  } dpStrobe_t;
endpackage

// File: rtl/soch_sync.sv
module soch_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pipe[0] <= {WIDTH{RESET_VAL}};
    else     pipe[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) pipe[s] <= {WIDTH{RESET_VAL}};
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/soch_ctrl.sv
module soch_ctrl
  import soch_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wrSync,
  input  logic      ackSync,
  input  logic      modeWrite,
  input  logic      inteSet,
  input  logic      inteClr,
  output dpStrobe_t strobe,
  output logic      fullQ,
  output logic      inteQ,
  output logic      intrQ
);
  logic wrPrev;
  logic wrRise;

  assign wrRise = wrSync & ~wrPrev;

  assign strobe.clearAll = modeWrite;
  assign strobe.loadData = wrRise;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) wrPrev <= 1'b1;
    else     wrPrev <= wrSync;
  end

  // buffer-full flag: mode clear, then write, then acknowledge
  always_ff @(posedge clk or posedge rst) begin
    if (rst)            fullQ <= 1'b0;
    else if (modeWrite) fullQ <= 1'b0;
    else if (wrRise)    fullQ <= 1'b1;
    else if (!ackSync)  fullQ <= 1'b0;
  end

  // interrupt enable: clear wins over set
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                        inteQ <= 1'b0;
    else if (modeWrite || inteClr)  inteQ <= 1'b0;
    else if (inteSet)               inteQ <= 1'b1;
  end

  // interrupt: raised when the channel is idle and emptied, dropped while the write strobe is low
  always_ff @(posedge clk or posedge rst) begin
    if (rst) intrQ <= 1'b0;
    else     intrQ <= ~modeWrite & inteQ & wrSync & ackSync & ~fullQ;
  end

  a_r2_write_sets: assert property (@(posedge clk) disable iff (rst)
    (wrRise && !modeWrite) |=> fullQ);

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (!ackSync && !wrRise && !modeWrite) |=> !fullQ);

  a_r5_wr_low_drops_intr: assert property (@(posedge clk) disable iff (rst)
    (!wrSync) |=> !intrQ);

  a_r6_mask_blocks_intr: assert property (@(posedge clk) disable iff (rst)
    (!inteQ) |=> !intrQ);

  a_r7_mode_clears: assert property (@(posedge clk) disable iff (rst)
    modeWrite |=> (!fullQ && !inteQ && !intrQ));
endmodule

// File: rtl/soch_datapath.sv
module soch_datapath
  import soch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] cpuData,
  output logic [DATA_W-1:0] dataQ
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                  dataQ <= '0;
    else if (strobe.clearAll) dataQ <= '0;
    else if (strobe.loadData) dataQ <= cpuData;
  end

  a_r2_latch_loads: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadData && !strobe.clearAll) |=> (dataQ == $past(cpuData)));

  a_r7_latch_cleared: assert property (@(posedge clk) disable iff (rst)
    strobe.clearAll |=> (dataQ == '0));
endmodule

// File: rtl/strobe_out_channel.sv
module strobe_out_channel
  import soch_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit BIDIR       = 1'b0,
  parameter bit GROUP_B     = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpuWrN,
  input  logic [DATA_W-1:0]   cpuData,
  input  logic                ackN,
  input  logic                modeWrite,
  input  logic                inteSet,
  input  logic                inteClr,
  output logic                obfN,
  output logic [DATA_W-1:0]   portOut,
  output logic                portOe,
  output logic                intr,
  output logic [STATUS_W-1:0] status
);
  logic [1:0] syncVec;
  logic       wrSync;
  logic       ackSync;
  dpStrobe_t  strobe;
  logic       fullQ;
  logic       inteQ;
  logic       intrQ;

  soch_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .asyncIn({cpuWrN, ackN}), .syncOut(syncVec)
  );
  assign wrSync  = syncVec[1];
  assign ackSync = syncVec[0];

  soch_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrSync(wrSync), .ackSync(ackSync),
    .modeWrite(modeWrite), .inteSet(inteSet), .inteClr(inteClr),
    .strobe(strobe), .fullQ(fullQ), .inteQ(inteQ), .intrQ(intrQ)
  );

  soch_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cpuData(cpuData), .dataQ(portOut)
  );

  assign obfN = ~fullQ;
  assign intr = intrQ;

  if (BIDIR) begin : g_bidir
    assign portOe = ~ackSync;
  end else begin : g_uni
    assign portOe = 1'b1;
  end

  if (GROUP_B) begin : g_statB
    assign status = {inteQ, ~fullQ, intrQ};
  end else begin : g_statA
    assign status = {~fullQ, inteQ, intrQ};
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (obfN && !intr && portOut == '0));
endmodule

// File: tb/test_strobe_out_channel.sv
module test_strobe_out_channel;
  localparam int DW = 8;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpuWrN = 1'b1;
  logic [DW-1:0] cpuData = '0;
  logic ackN = 1'b1;
  logic modeWrite = 1'b0;
  logic inteSet = 1'b0;
  logic inteClr = 1'b0;

  logic obfA, oeA, intrA, obfB, oeB, intrB;
  logic [DW-1:0] outA, outB;
  logic [2:0] stA, stB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  strobe_out_channel #(.DATA_W(DW), .SYNC_STAGES(SS), .BIDIR(1'b1), .GROUP_B(1'b0)) i_strobe_out_channel (
    .clk(clk), .rst(rst), .cpuWrN(cpuWrN), .cpuData(cpuData), .ackN(ackN),
    .modeWrite(modeWrite), .inteSet(inteSet), .inteClr(inteClr),
    .obfN(obfA), .portOut(outA), .portOe(oeA), .intr(intrA), .status(stA)
  );

  strobe_out_channel #(.DATA_W(DW), .SYNC_STAGES(SS), .BIDIR(1'b0), .GROUP_B(1'b1)) i_strobe_out_channel_b (
    .clk(clk), .rst(rst), .cpuWrN(cpuWrN), .cpuData(cpuData), .ackN(ackN),
    .modeWrite(modeWrite), .inteSet(inteSet), .inteClr(inteClr),
    .obfN(obfB), .portOut(outB), .portOe(oeB), .intr(intrB), .status(stB)
  );

  // behavioural reference: delay queues for the synchronizer, flags for the handshake
  logic wrQ[$];
  logic ackQ[$];
  logic mFull = 1'b0, mInte = 1'b0, mIntr = 1'b0, mWrPrev = 1'b1;
  logic [DW-1:0] mData = '0;

  function automatic logic qTail(logic q[$]);
    return q[q.size()-1];
  endfunction

  initial begin
    for (int i = 0; i < SS; i++) begin wrQ.push_front(1'b1); ackQ.push_front(1'b1); end
  end

  always @(posedge clk) begin
    if (rst) begin
      mFull <= 1'b0; mInte <= 1'b0; mIntr <= 1'b0; mWrPrev <= 1'b1; mData <= '0;
      wrQ.delete(); ackQ.delete();
      for (int i = 0; i < SS; i++) begin wrQ.push_front(1'b1); ackQ.push_front(1'b1); end
    end else begin
      automatic logic w = qTail(wrQ);
      automatic logic a = qTail(ackQ);
      automatic logic rise = w && !mWrPrev;
      if (modeWrite) mFull <= 1'b0;
      else if (rise) mFull <= 1'b1;
      else if (!a) mFull <= 1'b0;
      if (modeWrite || inteClr) mInte <= 1'b0;
      else if (inteSet) mInte <= 1'b1;
      mIntr <= !modeWrite && mInte && w && a && !mFull;
      if (modeWrite) mData <= '0;
      else if (rise) mData <= cpuData;
      mWrPrev <= w;
      void'(wrQ.pop_back()); wrQ.push_front(cpuWrN);
      void'(ackQ.pop_back()); ackQ.push_front(ackN);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      automatic logic a = qTail(ackQ);
      chk("R2 R3 R8", "obfN A", obfA, !mFull);
      chk("R2 R3 R8", "obfN B", obfB, !mFull);
      chk("R2 R7", "portOut A", outA, mData);
      chk("R2 R7", "portOut B", outB, mData);
      chk("R4 R5 R6", "intr A", intrA, mIntr);
      chk("R4 R5 R6", "intr B", intrB, mIntr);
      chk("R9", "portOe bidir", oeA, !a);
      chk("R9", "portOe uni", oeB, 1);
      chk("R10", "status A", stA, {!mFull, mInte, mIntr});
      chk("R10", "status B", stB, {mInte, !mFull, mIntr});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpuWrite(logic [DW-1:0] d);
    cpuData = d; cpuWrN = 1'b0; cyc(3);
    cpuWrN = 1'b1; cyc(SS + 3);
  endtask

  task automatic ackPulse(int n);
    ackN = 1'b0; cyc(n); ackN = 1'b1; cyc(SS + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk("R1", "obfN", obfA, 1); chk("R1", "intr", intrA, 0);
    chk("R1", "portOut", outA, 0); chk("R1", "inte", stA[1], 0);

    // R6: enable flag set through its input
    inteSet = 1'b1; cyc(1); inteSet = 1'b0; cyc(1);
    chk("R6", "inte set A", stA[1], 1); chk("R6", "inte set B", stB[2], 1);
    cyc(2);
    chk("R4", "intr idle with enable", intrA, 1);

    // R5: write strobe low drops the interrupt
    cpuData = 8'hA5; cpuWrN = 1'b0; cyc(SS + 2);
    chk("R5", "intr during write", intrA, 0);
    cpuWrN = 1'b1; cyc(SS + 2);
    // R2: data latched and buffer full
    chk("R2", "obfN after write", obfA, 0); chk("R2", "portOut", outA, 8'hA5);
    chk("R4", "intr while full", intrA, 0);

    // R3 / R4: acknowledge empties, interrupt follows release
    ackN = 1'b0; cyc(SS + 1);
    chk("R3", "obfN during ack", obfA, 1); chk("R9", "oe during ack", oeA, 1);
    ackN = 1'b1; cyc(SS + 2);
    chk("R9", "oe released", oeA, 0); chk("R4", "intr after ack", intrA, 1);

    // R8: write edge coinciding with a one-cycle acknowledge
    cpuData = 8'h3C; cpuWrN = 1'b0; cyc(3);
    cpuWrN = 1'b1; ackN = 1'b0; cyc(1); ackN = 1'b1; cyc(SS + 3);
    chk("R8", "write wins obfN", obfA, 0); chk("R8", "write wins data", outA, 8'h3C);
    ackPulse(4);

    // R6: clear wins over set; masked interrupt
    inteSet = 1'b1; inteClr = 1'b1; cyc(1); inteSet = 1'b0; inteClr = 1'b0; cyc(2);
    chk("R6", "clear wins", stA[1], 0); chk("R6", "intr masked", intrA, 0);

    // R7: mode write clears everything
    inteSet = 1'b1; cyc(1); inteSet = 1'b0;
    cpuWrite(8'h5A);
    modeWrite = 1'b1; cyc(1); modeWrite = 1'b0; cyc(1);
    chk("R7", "obfN", obfA, 1); chk("R7", "portOut", outA, 0);
    chk("R7", "inte", stA[1], 0); chk("R7", "intr", intrA, 0);

    // mixed stimulus, compared cycle by cycle against the model
    for (int i = 0; i < 400; i++) begin
      automatic int r = $urandom_range(0, 9);
      cpuData = DW'($urandom);
      inteSet = ($urandom_range(0, 7) == 0);
      inteClr = ($urandom_range(0, 15) == 0);
      modeWrite = ($urandom_range(0, 40) == 0);
      if (r < 2) cpuWrN = ~cpuWrN;
      if (r > 7) ackN = ~ackN;
      cyc(1);
    end
    cpuWrN = 1'b1; ackN = 1'b1; inteSet = 1'b0; inteClr = 1'b0; modeWrite = 1'b0;
    cyc(SS + 3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule